// File: doc/BRIEF.md
# Polyphase Horizontal Resampler

This block changes the horizontal sample rate of a line of 8-bit luminance by a fractional ratio. It can enlarge or shrink the line. A fixed-point position accumulator walks across the input line in steps of `cfg_step`. The integer part of the accumulator names the centre input sample. The top fractional bits pick one of sixteen coefficient sets. Each output pixel is a 7-tap weighted sum of the input samples around that centre. The sum is rounded and then clamped to the 8-bit range.

Software fills the coefficient table one entry per write through a small register port. It programs the step, the input line length and the output line length. Samples then arrive on a valid/ready stream, and the first sample of a line carries a start-of-line flag. Exactly `cfg_out_len` pixels leave on a registered valid/ready stream. At either end of the line, the edge sample stands in for positions that lie outside the line. The block keeps only the 7-sample window and no line store.

Top module: `poly_hscaler`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A write with `cfg_we` high stores `cfg_wdata` as the signed coefficient for phase `cfg_addr[6:3]` and tap `cfg_addr[2:0]`. A write whose tap field is 7 changes no stored coefficient.
- R3: Output pixel k uses position P = k * step. The step has 12 fractional bits. The centre is n = P >> 12 and the phase is bits [11:8] of P. Tap t (0..6) weights input sample x[n + t - 3].
- R4: An input index below 0 reads as x[0]. An index at or above `cfg_in_len` reads as x[cfg_in_len - 1].
- R5: The weighted sum has coefficients with 8 fractional bits. It is rounded by adding 128 and shifting right arithmetically by 8. It is then clamped to 0..255.
- R6: A sample with `in_sol` high, accepted while idle, restarts the position at 0. Exactly `cfg_out_len` pixels are produced for that line, after which the block is idle with `out_valid` low.
- R7: A sample accepted while idle without `in_sol` is discarded. It has no effect on later output.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value. No pixel is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 7 | Coefficient address {phase[3:0], tap[2:0]} |
| cfg_wdata | input | 10 | Signed coefficient, 8 fractional bits |
| cfg_step | input | 16 | Position step, 12 fractional bits |
| cfg_in_len | input | 12 | Input samples per line (at least 1) |
| cfg_out_len | input | 12 | Output pixels per line |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted |
| in_sol | input | 1 | Marks the first sample of a line |
| in_data | input | 8 | Input luminance sample |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the pixel |
| out_data | output | 8 | Output pixel |

## Verification
Two situations are hard to reach from the ports. The first is a pixel that is due while the window still has to advance by several samples. The second is a window that advances past the last input sample, so the edge sample must be replayed without any input being consumed. The stimulus reaches the first with downscale steps above 3.0. It reaches the second with upscale steps whose last positions fall beyond the line end. Both run under random output backpressure. Single-tap coefficient sets on tap 0 and tap 6 make the edge replay visible directly in the output values.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } hrs_state_e;
endpackage

// File: rtl/hrs_coef_bank.sv
module hrs_coef_bank #(
   parameter int CW     = 10,
   parameter int TAPS   = 7,
   parameter int PHASES = 16,
   localparam int PHB   = $clog2(PHASES),
   localparam int TAPW  = $clog2(TAPS),
   localparam int AW    = PHB + TAPW
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [AW-1:0]              addr,
   input  logic [CW-1:0]              wdata,
   input  logic [PHB-1:0]             rd_phase,
   output logic [TAPS-1:0][CW-1:0]    rd_coef
);
   logic [PHASES-1:0][TAPS-1:0][CW-1:0] bank;
   logic [TAPW-1:0]                     wr_tap;
   logic [PHB-1:0]                      wr_ph;
   logic                                wr_ok;

   assign wr_tap = addr[TAPW-1:0];
   assign wr_ph  = addr[AW-1:TAPW];
   assign wr_ok  = we && (int'(wr_tap) < TAPS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank <= '0;
      end else if (wr_ok) begin
         bank[wr_ph][wr_tap] <= wdata;
      end
   end

   assign rd_coef = bank[rd_phase];

   // an address whose tap field is past the last tap must leave every entry alone
   assert_bad_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && (int'(wr_tap) >= TAPS)) |=> $stable(bank));
endmodule

// File: rtl/hrs_window.sv
module hrs_window #(
   parameter int DW   = 8,
   parameter int TAPS = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    shift,
   input  logic                    take,
   input  logic [DW-1:0]           din,
   output logic [TAPS-1:0][DW-1:0] win
);
   logic [DW-1:0] nxt;

   assign nxt = take ? din : win[TAPS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win <= '0;
      end else if (load) begin
         for (int t = 0; t < TAPS; t++) win[t] <= din;
      end else if (shift) begin
         win <= {nxt, win[TAPS-1:1]};
      end
   end

   // past the end of the line the newest sample is replayed
   assert_edge_repeat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && !take && !load) |=> (win[TAPS-1] == $past(win[TAPS-1])) &&
                                    (win[TAPS-2] == $past(win[TAPS-1])));
endmodule

// File: rtl/hrs_mac.sv
module hrs_mac #(
   parameter int DW    = 8,
   parameter int CW    = 10,
   parameter int CFRAC = 8,
   parameter int TAPS  = 7
) (
   input  logic [TAPS-1:0][DW-1:0] win,
   input  logic [TAPS-1:0][CW-1:0] coef,
   output logic [DW-1:0]           pix
);
   localparam int PW = CW + DW + 1;
   localparam int SW = PW + $clog2(TAPS) + 1;

   logic signed [PW-1:0] prod [TAPS];
   logic signed [SW-1:0] total;
   logic signed [SW-1:0] biased;
   logic signed [SW-1:0] scaled;

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      assign prod[t] = $signed(coef[t]) * $signed({1'b0, win[t]});
   end

   always_comb begin
      total = '0;
      for (int t = 0; t < TAPS; t++) begin
         total = total + {{(SW-PW){prod[t][PW-1]}}, prod[t]};
      end
   end

   assign biased = total + SW'(1 << (CFRAC - 1));
   assign scaled = biased >>> CFRAC;

   always_comb begin
      if (scaled[SW-1])          pix = '0;
      else if (|scaled[SW-2:DW]) pix = '1;
      else                       pix = scaled[DW-1:0];
   end
endmodule

// File: rtl/hrs_dda.sv
module hrs_dda
   import hrs_pkg::*;
#(
   parameter int STEPW = 16,
   parameter int SFRAC = 12,
   parameter int PHB   = 4,
   parameter int LENW  = 12,
   parameter int TAPS  = 7,
   localparam int ACCW  = LENW + STEPW,
   localparam int JW    = ACCW - SFRAC + 1,
   localparam int NEEDW = STEPW - SFRAC + 1,
   localparam int HALF  = TAPS / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sol,
   input  logic [STEPW-1:0] step,
   input  logic [LENW-1:0]  in_len,
   input  logic [LENW-1:0]  out_len,
   input  logic             out_busy,
   output logic             in_ready,
   output logic             load,
   output logic             shift,
   output logic             take,
   output logic             emit,
   output logic [PHB-1:0]   phase
);
   hrs_state_e        st;
   logic [ACCW-1:0]   acc;
   logic [ACCW-1:0]   acc_nx;
   logic [NEEDW-1:0]  need;
   logic [NEEDW-1:0]  gap;
   logic [JW-1:0]     j;
   logic [LENW-1:0]   k;
   logic              more;
   logic              run;

   assign run    = (st == ST_RUN);
   assign more   = (j + JW'(1)) < JW'(in_len);
   assign acc_nx = acc + ACCW'(step);
   assign gap    = NEEDW'(acc_nx[ACCW-1:SFRAC] - acc[ACCW-1:SFRAC]);
   assign phase  = acc[SFRAC-1 -: PHB];

   assign in_ready = !run || (need != '0 && more);
   assign load     = !run && in_valid && in_sol && (out_len != '0);
   assign shift    = run && (need != '0) && (!more || in_valid);
   assign take     = shift && more;
   assign emit     = run && (need == '0) && !out_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         acc  <= '0;
         need <= '0;
         j    <= '0;
         k    <= '0;
      end else if (load) begin
         st   <= ST_RUN;
         acc  <= '0;
         need <= NEEDW'(HALF);
         j    <= '0;
         k    <= '0;
      end else if (shift) begin
         need <= need - NEEDW'(1);
         j    <= j + JW'(1);
      end else if (emit) begin
         acc  <= acc_nx;
         need <= gap;
         k    <= k + LENW'(1);
         if (k == out_len - LENW'(1)) st <= ST_IDLE;
      end
   end

   assert_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      emit |-> (k < out_len));

   assert_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && in_valid && !in_sol) |=> !run);
endmodule

// File: rtl/poly_hscaler.sv
module poly_hscaler #(
   parameter int DW     = 8,
   parameter int CW     = 10,
   parameter int CFRAC  = 8,
   parameter int TAPS   = 7,
   parameter int PHASES = 16,
   parameter int STEPW  = 16,
   parameter int SFRAC  = 12,
   parameter int LENW   = 12,
   localparam int PHB   = $clog2(PHASES),
   localparam int TAPW  = $clog2(TAPS),
   localparam int AW    = PHB + TAPW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [CW-1:0]    cfg_wdata,
   input  logic [STEPW-1:0] cfg_step,
   input  logic [LENW-1:0]  cfg_in_len,
   input  logic [LENW-1:0]  cfg_out_len,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_sol,
   input  logic [DW-1:0]    in_data,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [DW-1:0]    out_data
);
   if (TAPS % 2 != 1) begin : g_chk_taps
      $error("TAPS must be odd");
   end
   if ((1 << PHB) != PHASES) begin : g_chk_ph
      $error("PHASES must be a power of two");
   end
   if (SFRAC < PHB || STEPW <= SFRAC) begin : g_chk_step
      $error("step needs at least PHB fractional and one integer bit");
   end
   if (CFRAC < 1 || CFRAC >= CW + DW) begin : g_chk_cf
      $error("CFRAC out of range");
   end

   logic [TAPS-1:0][CW-1:0] coef;
   logic [TAPS-1:0][DW-1:0] win;
   logic [PHB-1:0]          phase;
   logic [DW-1:0]           pix;
   logic                    load, shift, take, emit;

   hrs_coef_bank #(.CW(CW), .TAPS(TAPS), .PHASES(PHASES)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rd_phase(phase), .rd_coef(coef));

   hrs_dda #(.STEPW(STEPW), .SFRAC(SFRAC), .PHB(PHB), .LENW(LENW), .TAPS(TAPS)) u_dda (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
      .step(cfg_step), .in_len(cfg_in_len), .out_len(cfg_out_len),
      .out_busy(out_valid && !out_ready), .in_ready(in_ready),
      .load(load), .shift(shift), .take(take), .emit(emit), .phase(phase));

   hrs_window #(.DW(DW), .TAPS(TAPS)) u_win (
      .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .take(take),
      .din(in_data), .win(win));

   hrs_mac #(.DW(DW), .CW(CW), .CFRAC(CFRAC), .TAPS(TAPS)) u_mac (
      .win(win), .coef(coef), .pix(pix));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (emit) begin
         out_valid <= 1'b1;
         out_data  <= pix;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/poly_hscaler_bench.sv
module poly_hscaler_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [6:0]  cfg_addr = '0;
   logic [9:0]  cfg_wdata = '0;
   logic [15:0] cfg_step = 16'h1000;
   logic [11:0] cfg_in_len = 12'd16;
   logic [11:0] cfg_out_len = 12'd16;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic        in_sol = 1'b0;
   logic [7:0]  in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [7:0]  out_data;

   int checks = 0;
   int errors = 0;
   int cm [16][7];
   int xl [64];

   always #5 clk = ~clk;

   poly_hscaler u_poly_hscaler (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_step(cfg_step), .cfg_in_len(cfg_in_len),
      .cfg_out_len(cfg_out_len), .in_valid(in_valid), .in_ready(in_ready),
      .in_sol(in_sol), .in_data(in_data), .out_valid(out_valid),
      .out_ready(out_ready), .out_data(out_data));

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input int ph, input int tap, input int val);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = 7'((ph << 3) | tap);
      cfg_wdata = 10'(val);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // 0 identity, 1 mixed, 2 tap0 only, 3 tap6 only, 4 gain 511, 5 gain -256
   task automatic load_set(input int kind);
      for (int p = 0; p < 16; p++) begin
         for (int t = 0; t < 7; t++) begin
            int v;
            v = 0;
            case (kind)
               0: v = (t == 3) ? 256 : 0;
               1: case (t)
                     0: v = p - 8;
                     1: v = -2 * p;
                     2: v = 40 - 2 * p;
                     3: v = 256 - 12 * p;
                     4: v = 12 * p - 20;
                     5: v = 3 * p;
                     default: v = -p;
                  endcase
               2: v = (t == 0) ? 256 : 0;
               3: v = (t == 6) ? 256 : 0;
               4: v = (t == 3) ? 511 : 0;
               default: v = (t == 3) ? -256 : 0;
            endcase
            cm[p][t] = v;
            wr(p, t, v);
         end
      end
   endtask

   function automatic int xe(input int i, input int n);
      if (i < 0) return xl[0];
      if (i >= n) return xl[n-1];
      return xl[i];
   endfunction

   function automatic int model(input int k, input int step, input int n);
      int pos, c, ph, s, r;
      pos = k * step;
      c = pos >> 12;
      ph = (pos >> 8) & 15;
      s = 0;
      for (int t = 0; t < 7; t++) s += cm[ph][t] * xe(c + t - 3, n);
      r = (s + 128) >>> 8;
      if (r < 0) r = 0;
      if (r > 255) r = 255;
      return r;
   endfunction

   task automatic send(input int d, input bit sol);
      in_data = 8'(d);
      in_sol = sol;
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_sol = 1'b0;
   endtask

   task automatic feed(input int n, input int junk);
      for (int i = 0; i < junk; i++) send(255 - i * 40, 1'b0);
      for (int i = 0; i < n; i++) send(xl[i], i == 0);
   endtask

   task automatic collect(input int m, input int step, input int n,
                          input bit stall, input string tag);
      int got;
      bit hold;
      int hdat;
      got = 0;
      hold = 0;
      hdat = 0;
      while (got < m) begin
         @(negedge clk);
         if (hold) begin
            check({tag, " R8 hold valid"}, int'(out_valid), 1);
            check({tag, " R8 hold data"}, int'(out_data), hdat);
         end
         out_ready = stall ? (($urandom % 3) != 0) : 1'b1;
         hold = out_valid && !out_ready;
         hdat = int'(out_data);
         if (out_valid && out_ready) begin
            check($sformatf("%s pixel %0d", tag, got), int'(out_data), model(got, step, n));
            got++;
         end
      end
   endtask

   task automatic run_line(input int n, input int m, input int step, input int seed,
                           input int junk, input bit stall, input string tag);
      for (int i = 0; i < n; i++) xl[i] = (i * 53 + seed * 29 + 7) & 255;
      cfg_in_len = 12'(n);
      cfg_out_len = 12'(m);
      cfg_step = 16'(step);
      fork
         feed(n, junk);
         collect(m, step, n, stall, tag);
      join
      out_ready = 1'b1;
      begin
         int extra;
         extra = 0;
         repeat (12) begin
            @(negedge clk);
            if (out_valid) extra++;
         end
         check({tag, " R6 no pixel past out_len"}, extra, 0);
         check({tag, " R6 idle after line"}, int'(in_ready), 1);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1 out_valid after reset", int'(out_valid), 0);
      check("R1 in_ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_identity;
      load_set(0);
      wr(0, 7, 511);   // R2: tap field 7 must not land anywhere
      wr(9, 7, -300);
      run_line(16, 16, 16'h1000, 1, 0, 1'b0, "R2 R3 identity");
   endtask

   task automatic t_upscale;
      load_set(1);
      run_line(16, 24, 16'h0A00, 2, 0, 1'b1, "R3 upscale 0.625");
      run_line(12, 24, 16'h0C00, 3, 0, 1'b1, "R4 upscale past end");
   endtask

   task automatic t_downscale;
      load_set(1);
      run_line(16, 10, 16'h1800, 4, 0, 1'b1, "R3 downscale 1.5");
      run_line(20, 5, 16'h3400, 5, 0, 1'b1, "R3 downscale 3.25");
   endtask

   task automatic t_edges;
      load_set(2);
      run_line(8, 8, 16'h1000, 6, 0, 1'b0, "R4 left edge");
      load_set(3);
      run_line(8, 8, 16'h1000, 7, 0, 1'b1, "R4 right edge");
      run_line(1, 4, 16'h0800, 8, 0, 1'b0, "R4 one sample line");
   endtask

   task automatic t_clamp;
      load_set(4);
      run_line(16, 16, 16'h1000, 9, 0, 1'b0, "R5 clamp high");
      load_set(5);
      run_line(16, 8, 16'h1000, 10, 0, 1'b1, "R5 clamp low");
      load_set(1);
      run_line(16, 20, 16'h0B40, 11, 0, 1'b0, "R5 rounding mixed");
   endtask

   task automatic t_discard;
      load_set(0);
      run_line(10, 10, 16'h1000, 12, 3, 1'b0, "R7 junk before line");
      load_set(1);
      run_line(16, 13, 16'h1380, 13, 2, 1'b1, "R6 R7 restart after junk");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_identity();
      t_upscale();
      t_downscale();
      t_edges();
      t_clamp();
      t_discard();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule